// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 synchronous interrupt request lines and presents them to a processor core as one normal interrupt output and one fast interrupt output. Each source has a programmable 3-bit priority, a choice between edge and level triggering, and a 32-bit vector word. Software masks sources through an enable set, marks them as pending or not through command registers, and can send any source to the fast path through a fast-forcing mask. Source 0 always uses the fast path.

Service runs through a register handshake. A read of the acknowledge register picks the best eligible source, returns its vector, records it as the active source and pushes its priority onto a stack of active levels. A write to the retire register pops that stack. The normal output is raised only when some source outranks the level on top of the stack, so a higher-priority source can preempt a running handler while equal or lower ones wait. When nothing qualifies, the acknowledge read returns a programmable spurious vector.

The bus is a single-cycle request with a write flag. Read data comes back one cycle after the request, marked by a valid strobe. Register offsets, as byte addresses: 0x000+4n is the mode word of source n (priority in bits 2:0, edge select in bit 5) and 0x080+4n its vector. 0x100 is acknowledge and 0x104 the fast vector. 0x108 is the active source, 0x10C pending, 0x110 enable and 0x114 core status (bit 1 normal request active, bit 0 fast request active). 0x120 and 0x124 set and clear enable bits, 0x128 and 0x12C clear and set pending bits. 0x130 is retire, 0x134 the spurious vector and 0x138 global mask (bit 1). 0x140 and 0x144 set and clear fast bits, and 0x148 reads the fast mask.

Top module: `prio_intc`

## Requirements
- R1: After reset both outputs are low, the enable and pending masks and the active-source register read 0, and the fast mask reads 0x00000001.
- R2: A read request returns its data with bus_rvalid high on the next cycle. A mode word reads back with the priority in bits 2:0 and the edge flag in bit 5.
- R3: The command registers act only on bits written as 1: set and clear of enable bits, set and clear of pending bits.
- R4: A source in edge mode (bit 5 = 1) becomes pending on a 0-to-1 change of its line. A source in level mode has its pending bit follow its line each cycle.
- R5: irq_o rises one cycle after some source that is enabled, pending and not fast has a priority strictly above the stack top, and global mask bit 1 is clear. Otherwise irq_o is low.
- R6: An acknowledge read returns the vector of the eligible source with the highest priority that is at least the stack top, with the lower index winning ties. Source 0 is never chosen. The read writes that index to the active-source register and pushes its priority.
- R7: An acknowledged edge-mode source has its pending bit cleared; an acknowledged level-mode source keeps it while its line stays high.
- R8: An acknowledge read with no qualifying source returns the spurious vector and changes neither the stack nor the active-source register.
- R9: A write of any value to retire clears the active-source register and pops one stack level. A pop at the base level, which ranks below every priority, leaves it in place.
- R10: Bit 0 of the fast mask cannot be cleared. fiq_o is high when any fast source is enabled and pending, and the fast vector read then returns vector word 0, otherwise the spurious vector.
- R11: While a handler of priority p is active, a pending source of priority p does not raise irq_o, and one of priority above p does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq_in | input | 32 | Synchronous interrupt request lines |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
On every cycle the assertions check the read latency, that fast bit 0 stays set, that irq_o never rises while the global mask is set, that enable-set bits land, that retire clears the active source, and that the level stack keeps its pointer in range, pushes the right level and does not pop below its base. The choice of winner among many pending sources, the tie rule, preemption across nested levels, the edge and level pending rules and the spurious cases are shown only by the bench's scenarios. Those scenarios compare vectors and outputs against values worked out from the requirements.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
    localparam int N_SRC       = 32;
    localparam int DATA_W      = 32;
    localparam int LVL_W       = 3;
    localparam int STACK_DEPTH = 9;
    localparam int ADDR_W      = 9;

    localparam logic [ADDR_W-1:0] OFS_ACK      = 9'h100;
    localparam logic [ADDR_W-1:0] OFS_FAST_VEC = 9'h104;
    localparam logic [ADDR_W-1:0] OFS_ACTIVE   = 9'h108;
    localparam logic [ADDR_W-1:0] OFS_PEND     = 9'h10C;
    localparam logic [ADDR_W-1:0] OFS_ENA      = 9'h110;
    localparam logic [ADDR_W-1:0] OFS_CORE     = 9'h114;
    localparam logic [ADDR_W-1:0] OFS_ENA_SET  = 9'h120;
    localparam logic [ADDR_W-1:0] OFS_ENA_CLR  = 9'h124;
    localparam logic [ADDR_W-1:0] OFS_PEND_CLR = 9'h128;
    localparam logic [ADDR_W-1:0] OFS_PEND_SET = 9'h12C;
    localparam logic [ADDR_W-1:0] OFS_RETIRE   = 9'h130;
    localparam logic [ADDR_W-1:0] OFS_SPUR     = 9'h134;
    localparam logic [ADDR_W-1:0] OFS_GMASK    = 9'h138;
    localparam logic [ADDR_W-1:0] OFS_FAST_SET = 9'h140;
    localparam logic [ADDR_W-1:0] OFS_FAST_CLR = 9'h144;
    localparam logic [ADDR_W-1:0] OFS_FAST     = 9'h148;

    localparam int EDGE_BIT  = 5;
    localparam int GMASK_BIT = 1;
endpackage

// File: rtl/prio_intc_pick.sv
module prio_intc_pick #(
    parameter int N_SRC = 32,
    parameter int LVL_W = 3,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]            elig,
    input  logic [N_SRC-1:0][LVL_W-1:0] prio,
    input  logic signed [LVL_W:0]       floor_lvl,
    output logic                        found,
    output logic [IDX_W-1:0]            win_idx,
    output logic [LVL_W-1:0]            win_lvl,
    output logic                        any_above
);
    logic signed [LVL_W:0] best;
    logic signed [LVL_W:0] cand;

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        best      = floor_lvl;
        found     = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        any_above = 1'b0;
        cand      = '0;
        for (int i = N_SRC - 1; i >= 1; i--) begin
            cand = $signed({1'b0, prio[i]});
            if (elig[i] && cand >= best) begin
                best    = cand;
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = prio[i];
            end
            if (elig[i] && cand > floor_lvl) begin
                any_above = 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_intc_stack.sv
module prio_intc_stack #(
    parameter int LVL_W = 3,
    parameter int DEPTH = 9,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  push,
    input  logic [LVL_W-1:0]      push_lvl,
    input  logic                  pop,
    output logic signed [LVL_W:0] top_lvl,
    output logic signed [LVL_W:0] top_lvl_next
);
    typedef struct packed {
        logic [PTR_W-1:0]                ptr;
        logic [DEPTH-1:1][LVL_W-1:0]     ent;
    } stk_t;

    stk_t stk_d, stk_q;

    always_comb begin
        stk_d = stk_q;
        if (push && (stk_q.ptr != PTR_W'(DEPTH - 1))) begin
            stk_d.ptr = stk_q.ptr + 1'b1;
            for (int i = 1; i < DEPTH; i++) begin
                if (stk_d.ptr == PTR_W'(i)) stk_d.ent[i] = push_lvl;
            end
        end else if (pop && (stk_q.ptr != '0)) begin
            stk_d.ptr = stk_q.ptr - 1'b1;
        end
    end

    // Entry 0 is the base level -1, below every priority.
    always_comb begin
        top_lvl      = '1;
        top_lvl_next = '1;
        for (int i = 1; i < DEPTH; i++) begin
            if (stk_q.ptr == PTR_W'(i)) top_lvl      = $signed({1'b0, stk_q.ent[i]});
            if (stk_d.ptr == PTR_W'(i)) top_lvl_next = $signed({1'b0, stk_d.ent[i]});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    // R9
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_q.ptr <= PTR_W'(DEPTH - 1));

    // R9
    pop_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && stk_q.ptr == '0) |=> (top_lvl == -1));

    // R6
    push_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && stk_q.ptr != PTR_W'(DEPTH - 1)) |=> (top_lvl == $signed({1'b0, $past(push_lvl)})));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import prio_intc_pkg::*;
#(
    parameter int NSRC   = N_SRC,
    parameter int DW     = DATA_W,
    parameter int PW     = LVL_W,
    parameter int SDEPTH = STACK_DEPTH,
    parameter int AW     = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_req,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic            bus_rvalid,
    input  logic [NSRC-1:0] irq_in,
    output logic            irq_o,
    output logic            fiq_o
);
    localparam int IDX_W = $clog2(NSRC);

    typedef struct packed {
        logic [NSRC-1:0]          ena;
        logic [NSRC-1:0]          pend;
        logic [NSRC-1:0]          fast;
        logic [NSRC-1:0]          edge_m;
        logic [NSRC-1:0]          lines;
        logic [NSRC-1:0][PW-1:0]  prio;
        logic [NSRC-1:0][DW-1:0]  vec;
        logic [DW-1:0]            spur;
        logic [DW-1:0]            rdata;
        logic [IDX_W-1:0]         active;
        logic                     gmask;
        logic                     rvalid;
    } regs_t;

    regs_t r_d, r_q;
    logic  irq_act_d, irq_act_q;
    logic  fiq_act_d, fiq_act_q;
    logic  irq_d, irq_q;

    logic                 rd, wr, in_mode, in_vec;
    logic [IDX_W-1:0]     sel;
    logic [NSRC-1:0]      elig_now, elig_next, rise;
    logic                 ack_push, eoi_pop;
    logic signed [PW:0]   lvl_now, lvl_next;
    logic                 now_found, now_above;
    logic [IDX_W-1:0]     now_idx;
    logic [PW-1:0]        now_lvl;
    logic                 nxt_found, nxt_above;
    logic [IDX_W-1:0]     nxt_idx;
    logic [PW-1:0]        nxt_lvl;

    assign rd       = bus_req && !bus_we;
    assign wr       = bus_req && bus_we;
    assign sel      = bus_addr[IDX_W+1:2];
    assign in_mode  = (bus_addr[AW-1:IDX_W+2] == '0);
    assign in_vec   = (bus_addr[AW-1:IDX_W+2] == 1);
    assign rise     = irq_in & ~r_q.lines;
    assign elig_now = r_q.ena & r_q.pend & ~r_q.fast;

    prio_intc_stack #(.LVL_W(PW), .DEPTH(SDEPTH)) u_stack (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (ack_push),
        .push_lvl     (now_lvl),
        .pop          (eoi_pop),
        .top_lvl      (lvl_now),
        .top_lvl_next (lvl_next)
    );

    prio_intc_pick #(.N_SRC(NSRC), .LVL_W(PW)) u_pick_ack (
        .elig      (elig_now),
        .prio      (r_q.prio),
        .floor_lvl (lvl_now),
        .found     (now_found),
        .win_idx   (now_idx),
        .win_lvl   (now_lvl),
        .any_above (now_above)
    );

    function automatic logic [DW-1:0] mode_word(logic [PW-1:0] p, logic e);
        logic [DW-1:0] w;
        w = '0;
        w[PW-1:0] = p;
        w[EDGE_BIT] = e;
        return w;
    endfunction

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = rd;
        r_d.lines  = irq_in;
        ack_push   = 1'b0;
        eoi_pop    = 1'b0;

        if (rd) begin
            r_d.rdata = '0;
            if (in_mode) begin
                r_d.rdata = mode_word(r_q.prio[sel], r_q.edge_m[sel]);
            end else if (in_vec) begin
                r_d.rdata = r_q.vec[sel];
            end else begin
                unique case (bus_addr)
                    OFS_ACK: begin
                        if (now_found) begin
                            r_d.rdata  = r_q.vec[now_idx];
                            r_d.active = now_idx;
                            ack_push   = 1'b1;
                            if (r_q.edge_m[now_idx]) r_d.pend[now_idx] = 1'b0;
                        end else begin
                            r_d.rdata = r_q.spur;
                        end
                    end
                    OFS_FAST_VEC: r_d.rdata = (|(r_q.ena & r_q.pend & r_q.fast)) ? r_q.vec[0] : r_q.spur;
                    OFS_ACTIVE:   r_d.rdata = DW'(r_q.active);
                    OFS_PEND:     r_d.rdata = DW'(r_q.pend);
                    OFS_ENA:      r_d.rdata = DW'(r_q.ena);
                    OFS_CORE:     r_d.rdata = DW'({irq_act_q, fiq_act_q});
                    OFS_FAST:     r_d.rdata = DW'(r_q.fast);
                    default:      r_d.rdata = '0;
                endcase
            end
        end

        if (wr) begin
            if (in_mode) begin
                r_d.prio[sel]   = bus_wdata[PW-1:0];
                r_d.edge_m[sel] = bus_wdata[EDGE_BIT];
            end else if (in_vec) begin
                r_d.vec[sel] = bus_wdata;
            end else begin
                unique case (bus_addr)
                    OFS_ENA_SET:  r_d.ena  = r_q.ena  |  bus_wdata[NSRC-1:0];
                    OFS_ENA_CLR:  r_d.ena  = r_q.ena  & ~bus_wdata[NSRC-1:0];
                    OFS_PEND_SET: r_d.pend = r_q.pend |  bus_wdata[NSRC-1:0];
                    OFS_PEND_CLR: r_d.pend = r_q.pend & ~bus_wdata[NSRC-1:0];
                    OFS_RETIRE: begin
                        r_d.active = '0;
                        eoi_pop    = 1'b1;
                    end
                    OFS_SPUR:     r_d.spur  = bus_wdata;
                    OFS_GMASK:    r_d.gmask = bus_wdata[GMASK_BIT];
                    OFS_FAST_SET: r_d.fast  = r_q.fast |  bus_wdata[NSRC-1:0];
                    OFS_FAST_CLR: r_d.fast  = r_q.fast & ~bus_wdata[NSRC-1:0];
                    default: ;
                endcase
            end
        end
        r_d.fast[0] = 1'b1;

        // Line effects come last so a fresh edge is never lost to an ack.
        for (int i = 0; i < NSRC; i++) begin
            if (r_q.edge_m[i]) begin
                if (rise[i]) r_d.pend[i] = 1'b1;
            end else begin
                r_d.pend[i] = irq_in[i];
            end
        end
    end

    assign elig_next = r_d.ena & r_d.pend & ~r_d.fast;

    prio_intc_pick #(.N_SRC(NSRC), .LVL_W(PW)) u_pick_eval (
        .elig      (elig_next),
        .prio      (r_d.prio),
        .floor_lvl (lvl_next),
        .found     (nxt_found),
        .win_idx   (nxt_idx),
        .win_lvl   (nxt_lvl),
        .any_above (nxt_above)
    );

    assign irq_act_d = nxt_above;
    assign fiq_act_d = |(r_d.ena & r_d.pend & r_d.fast);
    assign irq_d     = nxt_above && !r_d.gmask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.fast[0] <= 1'b1;
            irq_act_q   <= 1'b0;
            fiq_act_q   <= 1'b0;
            irq_q       <= 1'b0;
        end else begin
            r_q       <= r_d;
            irq_act_q <= irq_act_d;
            fiq_act_q <= fiq_act_d;
            irq_q     <= irq_d;
        end
    end

    assign bus_rdata  = r_q.rdata;
    assign bus_rvalid = r_q.rvalid;
    assign irq_o      = irq_q;
    assign fiq_o      = fiq_act_q;

    // R10
    fast0_pinned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.fast[0]);

    // R2
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we) |=> bus_rvalid);

    // R9
    retire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == OFS_RETIRE) |=> (r_q.active == '0));

    // R5
    irq_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !r_q.gmask);

    // R3
    ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == OFS_ENA_SET)
        |=> ((r_q.ena & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
    import prio_intc_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [31:0] irq_in = '0;
    logic        irq_o, fiq_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    prio_intc u_prio_intc (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_in(irq_in), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // Monitor: pops expected read data as results appear.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic set_line(input int i, input logic v);
        @(negedge clk);
        irq_in[i] = v;
        @(negedge clk);
    endtask

    task automatic chk(input logic act, input logic e, input string t);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", t, act, e);
        end
    endtask

    function automatic logic [8:0] mode_a(int i); return 9'(i * 4); endfunction
    function automatic logic [8:0] vec_a(int i);  return 9'(9'h080 + i * 4); endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(irq_o, 1'b0, "R1 irq_o after reset");
        chk(fiq_o, 1'b0, "R1 fiq_o after reset");
        rd(OFS_FAST, 32'h1, "R1 fast mask reset");
        rd(OFS_ENA, 32'h0, "R1 enable reset");
        rd(OFS_PEND, 32'h0, "R1 pending reset");
        rd(OFS_ACTIVE, 32'h0, "R1 active reset");

        // Configure sources
        wr(mode_a(3), 32'h22);
        wr(mode_a(5), 32'h25);
        wr(mode_a(7), 32'h02);
        wr(mode_a(9), 32'h25);
        for (int i = 0; i < 10; i++) wr(vec_a(i), 32'h1000 + i);
        wr(vec_a(0), 32'hF00);
        wr(OFS_SPUR, 32'hDEAD);
        rd(mode_a(3), 32'h22, "R2 mode word readback");
        rd(vec_a(9), 32'h1009, "R2 vector readback");

        wr(OFS_ENA_SET, 32'h2A9);
        rd(OFS_ENA, 32'h2A9, "R3 enable set");
        wr(OFS_ENA_CLR, 32'h200);
        rd(OFS_ENA, 32'h0A9, "R3 enable clear only ones");
        wr(OFS_ENA_SET, 32'h200);
        rd(OFS_ENA, 32'h2A9, "R3 enable set again");

        // Edge source 3, priority 2
        set_line(3, 1'b1);
        chk(irq_o, 1'b1, "R5 irq_o on eligible edge source");
        rd(OFS_PEND, 32'h8, "R4 edge sets pending");
        wr(OFS_GMASK, 32'h2);
        chk(irq_o, 1'b0, "R5 global mask holds irq_o low");
        wr(OFS_GMASK, 32'h0);
        chk(irq_o, 1'b1, "R5 irq_o back after unmask");

        rd(OFS_ACK, 32'h1003, "R6 ack returns vector 3");
        chk(irq_o, 1'b0, "R7 irq_o drops after edge ack");
        rd(OFS_ACTIVE, 32'h3, "R6 active source 3");
        rd(OFS_PEND, 32'h0, "R7 edge pending cleared by ack");

        // Nesting: level source 7 at same priority waits
        set_line(7, 1'b1);
        chk(irq_o, 1'b0, "R11 equal priority does not preempt");
        rd(OFS_PEND, 32'h80, "R4 level pending follows line");
        @(negedge clk);
        irq_in[5] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        chk(irq_o, 1'b1, "R11 higher priority preempts");
        rd(OFS_ACK, 32'h1005, "R6 tie goes to lower index");
        chk(irq_o, 1'b0, "R11 equal level 5 waits");
        rd(OFS_ACK, 32'h1009, "R6 equal to stack top still acked");
        rd(OFS_ACTIVE, 32'h9, "R6 active source 9");
        wr(OFS_RETIRE, 32'h0);
        wr(OFS_RETIRE, 32'h0);
        chk(irq_o, 1'b0, "R9 back at level 2, source 7 waits");
        wr(OFS_RETIRE, 32'h12345678);
        chk(irq_o, 1'b1, "R9 pop to base releases source 7");
        rd(OFS_ACTIVE, 32'h0, "R9 retire clears active");
        rd(OFS_ACK, 32'h1007, "R6 ack level source 7");
        rd(OFS_PEND, 32'h80, "R7 level pending kept after ack");
        set_line(7, 1'b0);
        rd(OFS_PEND, 32'h0, "R4 level pending drops with line");
        wr(OFS_RETIRE, 32'h0);
        wr(OFS_RETIRE, 32'h0);
        rd(OFS_ACK, 32'hDEAD, "R8 nothing pending gives spurious");
        rd(OFS_ACTIVE, 32'h0, "R8 spurious leaves active clear");
        wr(OFS_PEND_SET, 32'h8);
        chk(irq_o, 1'b1, "R9 stack floor intact after extra pop");
        rd(OFS_ACK, 32'h1003, "R3 pending set acked");
        wr(OFS_RETIRE, 32'h0);

        // Disabled pending source is not chosen
        wr(OFS_ENA_CLR, 32'h20);
        wr(OFS_PEND_SET, 32'h20);
        chk(irq_o, 1'b0, "R5 disabled source no irq");
        rd(OFS_ACK, 32'hDEAD, "R8 disabled source spurious");
        wr(OFS_PEND_CLR, 32'h20);
        rd(OFS_PEND, 32'h0, "R3 pending clear");

        // Fast path
        set_line(0, 1'b1);
        chk(fiq_o, 1'b1, "R10 source 0 raises fiq_o");
        chk(irq_o, 1'b0, "R10 source 0 not on irq");
        rd(OFS_FAST_VEC, 32'hF00, "R10 fast vector word 0");
        rd(OFS_ACK, 32'hDEAD, "R6 source 0 never acked as irq");
        wr(OFS_FAST_CLR, 32'hFFFF_FFFF);
        rd(OFS_FAST, 32'h1, "R10 fast bit 0 pinned");
        wr(OFS_FAST_SET, 32'h20);
        wr(OFS_ENA_SET, 32'h20);
        wr(OFS_PEND_SET, 32'h20);
        set_line(0, 1'b0);
        chk(fiq_o, 1'b1, "R10 fast-forced source 5 keeps fiq_o");
        chk(irq_o, 1'b0, "R10 fast-forced source off irq path");
        rd(OFS_CORE, 32'h1, "R10 core status fast bit");
        wr(OFS_FAST_CLR, 32'h20);
        chk(fiq_o, 1'b0, "R10 fiq_o drops after unforce");
        chk(irq_o, 1'b1, "R5 source 5 back on irq path");
        rd(OFS_CORE, 32'h2, "R5 core status irq bit");
        rd(OFS_FAST_VEC, 32'hDEAD, "R10 no fast source gives spurious");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 reads unanswered actual=%0d expected=0", exp_q.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule